// File: doc/BRIEF.md
# DRAM Strobe-Order Cycle Decoder

This block sits on the device side of an asynchronous DRAM interface, for example inside a memory model or an emulator. It watches the four active-low control strobes (row strobe, column strobe, write enable, output enable) and works out what kind of access the host performed. It does this only from the order of the strobe edges. The possible results are a normal read, an early write, a read-modify-write, a row-only refresh, a column-before-row refresh, a test-mode entry, or an indeterminate write whose output data is undefined.

The strobes are brought into the local clock domain through a multi-stage synchronizer, and edges are detected on the synchronized copies. When the row strobe is released, the decoded cycle is reported as a 3-bit code for exactly one clock. A sticky test-mode flag is set by the test-entry ordering and cleared by either refresh ordering. Read data comes from the array as one pair of internal bits per data line. In normal mode the column-address MSB picks one bit of each pair. In test mode each line instead reports whether its two bits agree.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After the synchronized row strobe rises at the end of a cycle, `cyc_valid` goes high for exactly one clock, within SYNC_STAGES+2 clock edges of the pin change.
- R2: `cyc_type` encodes the cycle as 1 = read, 2 = early write, 3 = read-modify-write, 4 = row-only refresh, 5 = column-before-row refresh, 6 = test entry, 7 = indeterminate. It is 0 whenever `cyc_valid` is low.
- R3: If the column strobe is high when the row strobe falls and never falls during the cycle, the code is 4 and `dq_oe` stays low.
- R4: If the column strobe is already low when the row strobe falls and write enable is high, the code is 5.
- R5: If the column strobe and write enable are both low when the row strobe falls, the code is 6 and `test_mode` is set. It then stays set through reads and writes.
- R6: A cycle decoded as code 4 or code 5 clears `test_mode` when that cycle is reported.
- R7: In a normal-mode read with output enable low, `dq_oe` rises ACCESS_CYC clocks after the detected column-strobe fall. `dq_out[i]` is `arr_pair[2i+1]` when `col_sel` was 1 at the column-strobe fall, and `arr_pair[2i]` when it was 0.
- R8: In a test-mode read, `dq_out[i]` is 1 when `arr_pair[2i]` equals `arr_pair[2i+1]` and 0 otherwise, whatever the value of `col_sel`.
- R9: If write enable is low when the column-strobe fall is detected, the code is 2. `wr_accept` pulses once and `dq_oe` stays low for the whole cycle.
- R10: If write enable falls after the read data is ready, the code is 3. The read data is driven first, then `wr_accept` pulses once and `dq_oe` drops.
- R11: If write enable falls while the read access is still pending, the code is 7. `dq_x` is high while output enable is low, and `dq_oe` stays low.
- R12: With output enable held high, `dq_oe` stays low even after read data is ready.
- R13: After reset, `cyc_valid`, `cyc_type`, `test_mode`, `wr_accept`, `dq_oe` and `dq_x` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe pin, active low, asynchronous |
| cas_n | input | 1 | Column strobe pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| col_sel | input | 1 | Column-address MSB; picks one bit of each pair in normal mode |
| arr_pair | input | 2*DQ_W | Two internal array bits per data line |
| cyc_type | output | 3 | Decoded cycle code, valid with cyc_valid |
| cyc_valid | output | 1 | One-clock pulse at the end of each cycle |
| test_mode | output | 1 | Sticky test-mode flag |
| wr_accept | output | 1 | One-clock pulse when write data is taken |
| dq_out | output | DQ_W | Read data value |
| dq_oe | output | 1 | Read data drive enable |
| dq_x | output | 1 | Marker for undefined output during an indeterminate cycle |

## Verification
Every pin change reaches the decoder only after SYNC_STAGES clocks plus one edge-detect register. The cycle code therefore arrives about three clocks after the row strobe is released, and read data arrives about ACCESS_CYC+2 clocks after the column strobe falls. The bench does not sample the end-of-cycle code on a fixed edge. It polls a ten-clock window after releasing the row strobe, and in that window it counts how many clocks `cyc_valid` is high and records the code. Data and enable checks are taken only after holding the strobes for a settle time longer than the worst-case latency: twelve clocks after the column-strobe fall. Write-enable edges used to separate the indeterminate and read-modify-write cases are placed one clock and twelve clocks after the column strobe, so they land on either side of the access window.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

   typedef enum logic [2:0] {
      CT_NONE    = 3'd0,
      CT_READ    = 3'd1,
      CT_EWRITE  = 3'd2,
      CT_RMW     = 3'd3,
      CT_RASONLY = 3'd4,
      CT_CBR     = 3'd5,
      CT_TEST    = 3'd6,
      CT_INDET   = 3'd7
   } cyc_code_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ROW,
      ST_ACC,
      ST_RDY,
      ST_EWR,
      ST_RMW,
      ST_IND,
      ST_CBR,
      ST_TEN
   } dec_state_t;

endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
   parameter int STAGES = 2,
   parameter int N      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_in,
   output logic [N-1:0] lvl
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dcd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{ {N{1'b1}} }};
      end else begin
         chain <= {chain[STAGES-2:0], d_in};
      end
   end

   assign lvl = chain[STAGES-1];

endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
   import dcd_pkg::*;
#(
   parameter int ACCESS_CYC = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ras_l,
   input  logic      cas_l,
   input  logic      we_l,
   output cyc_code_t cyc_code,
   output logic      cyc_valid,
   output logic      test_mode,
   output logic      wr_accept,
   output logic      cap,
   output logic      col_take,
   output logic      rdy,
   output logic      indet
);

   localparam int CNT_W = (ACCESS_CYC < 2) ? 1 : $clog2(ACCESS_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_CYC - 1);

   generate
      if (ACCESS_CYC < 1) begin : g_bad_access
         $error("dcd_classifier: ACCESS_CYC must be at least 1");
      end
   endgenerate

   dec_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic             ras_p, cas_p, we_p;
   logic             ras_fall, ras_rise, cas_fall, we_fall;

   assign ras_fall = ras_p & ~ras_l;
   assign ras_rise = ~ras_p & ras_l;
   assign cas_fall = cas_p & ~cas_l;
   assign we_fall  = we_p & ~we_l;

   function automatic cyc_code_t code_of(input dec_state_t s);
      case (s)
         ST_ROW:  return CT_RASONLY;
         ST_ACC:  return CT_READ;
         ST_RDY:  return CT_READ;
         ST_EWR:  return CT_EWRITE;
         ST_RMW:  return CT_RMW;
         ST_IND:  return CT_INDET;
         ST_CBR:  return CT_CBR;
         ST_TEN:  return CT_TEST;
         default: return CT_NONE;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         ras_p     <= 1'b1;
         cas_p     <= 1'b1;
         we_p      <= 1'b1;
         cyc_code  <= CT_NONE;
         cyc_valid <= 1'b0;
         test_mode <= 1'b0;
         wr_accept <= 1'b0;
         cap       <= 1'b0;
      end else begin
         ras_p     <= ras_l;
         cas_p     <= cas_l;
         we_p      <= we_l;
         cyc_code  <= CT_NONE;
         cyc_valid <= 1'b0;
         wr_accept <= 1'b0;
         cap       <= 1'b0;
         if (st == ST_IDLE) begin
            if (ras_fall) begin
               if (!cas_l) st <= we_l ? ST_CBR : ST_TEN;
               else        st <= ST_ROW;
            end
         end else if (ras_rise) begin
            cyc_valid <= 1'b1;
            cyc_code  <= code_of(st);
            if (st == ST_TEN)                      test_mode <= 1'b1;
            else if (st == ST_ROW || st == ST_CBR) test_mode <= 1'b0;
            st <= ST_IDLE;
         end else begin
            case (st)
               ST_ROW: begin
                  if (cas_fall) begin
                     if (!we_l) begin
                        st        <= ST_EWR;
                        wr_accept <= 1'b1;
                     end else begin
                        st  <= ST_ACC;
                        cnt <= '0;
                     end
                  end
               end
               ST_ACC: begin
                  if (we_fall) begin
                     st <= ST_IND;
                  end else if (cnt == CNT_LAST) begin
                     st  <= ST_RDY;
                     cap <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_RDY: begin
                  if (we_fall) begin
                     st        <= ST_RMW;
                     wr_accept <= 1'b1;
                  end
               end
               default: st <= st;
            endcase
         end
      end
   end

   assign col_take = (st == ST_ROW) && cas_fall && !ras_rise;
   assign rdy      = (st == ST_RDY);
   assign indet    = (st == ST_IND);

endmodule

// File: rtl/dcd_datapath.sv
module dcd_datapath #(
   parameter int DQ_W        = 8,
   parameter bit TEST_CMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*DQ_W-1:0] arr_pair,
   input  logic              col_sel,
   input  logic              col_take,
   input  logic              cap,
   input  logic              test_mode,
   input  logic              rdy,
   input  logic              indet,
   input  logic              oe_l,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              dq_x
);

   logic            col_q;
   logic [DQ_W-1:0] sel_v;
   logic [DQ_W-1:0] nxt_v;

   genvar g;
   generate
      for (g = 0; g < DQ_W; g++) begin : g_sel
         assign sel_v[g] = col_q ? arr_pair[2*g+1] : arr_pair[2*g];
      end
      if (TEST_CMP_EN) begin : g_cmp
         logic [DQ_W-1:0] cmp_v;
         for (g = 0; g < DQ_W; g++) begin : g_bit
            assign cmp_v[g] = ~(arr_pair[2*g] ^ arr_pair[2*g+1]);
         end
         assign nxt_v = test_mode ? cmp_v : sel_v;
      end else begin : g_nocmp
         assign nxt_v = sel_v;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= 1'b0;
         dq_out <= '0;
      end else begin
         if (col_take) col_q  <= col_sel;
         if (cap)      dq_out <= nxt_v;
      end
   end

   assign dq_oe = rdy & ~oe_l;
   assign dq_x  = indet & ~oe_l;

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
   import dcd_pkg::*;
#(
   parameter int DQ_W        = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ACCESS_CYC  = 4,
   parameter bit TEST_CMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              col_sel,
   input  logic [2*DQ_W-1:0] arr_pair,
   output logic [2:0]        cyc_type,
   output logic              cyc_valid,
   output logic              test_mode,
   output logic              wr_accept,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              dq_x
);

   localparam int NSTB = 4;

   generate
      if (DQ_W < 1) begin : g_bad_width
         $error("dram_cycle_decoder: DQ_W must be at least 1");
      end
   endgenerate

   logic [NSTB-1:0] stb_raw, stb_s;
   cyc_code_t       code;
   logic            cap, col_take, rdy, indet;

   assign stb_raw = {oe_n, we_n, cas_n, ras_n};

   dcd_sync #(.STAGES(SYNC_STAGES), .N(NSTB)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (stb_raw),
      .lvl   (stb_s)
   );

   dcd_classifier #(.ACCESS_CYC(ACCESS_CYC)) u_cls (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_l     (stb_s[0]),
      .cas_l     (stb_s[1]),
      .we_l      (stb_s[2]),
      .cyc_code  (code),
      .cyc_valid (cyc_valid),
      .test_mode (test_mode),
      .wr_accept (wr_accept),
      .cap       (cap),
      .col_take  (col_take),
      .rdy       (rdy),
      .indet     (indet)
   );

   dcd_datapath #(.DQ_W(DQ_W), .TEST_CMP_EN(TEST_CMP_EN)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .arr_pair  (arr_pair),
      .col_sel   (col_sel),
      .col_take  (col_take),
      .cap       (cap),
      .test_mode (test_mode),
      .rdy       (rdy),
      .indet     (indet),
      .oe_l      (stb_s[3]),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe),
      .dq_x      (dq_x)
   );

   assign cyc_type = code;

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cyc_valid,
   input logic [2:0] cyc_type,
   input logic       test_mode,
   input logic       wr_accept,
   input logic       dq_oe,
   input logic       dq_x
);

   AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |=> !cyc_valid); // R1

   AST_TYPE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> (cyc_type == 3'd0)); // R2

   AST_TEST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_type == 3'd6) |-> test_mode); // R5

   AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(test_mode) |-> cyc_valid); // R5

   AST_TEST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && (cyc_type == 3'd4 || cyc_type == 3'd5)) |-> !test_mode); // R6

   AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> !dq_oe); // R9

   AST_OE_X_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dq_oe, dq_x})); // R11

endmodule

bind dram_cycle_decoder dcd_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_valid (cyc_valid),
   .cyc_type  (cyc_type),
   .test_mode (test_mode),
   .wr_accept (wr_accept),
   .dq_oe     (dq_oe),
   .dq_x      (dq_x)
);

// File: tb/dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module dram_cycle_decoder_bench;

   localparam int DQ_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
   logic              col_sel = 1'b0;
   logic [2*DQ_W-1:0] arr_pair = '0;
   logic [2:0]        cyc_type;
   logic              cyc_valid, test_mode, wr_accept, dq_oe, dq_x;
   logic [DQ_W-1:0]   dq_out;

   int nchk  = 0;
   int nfail = 0;
   int ncyc  = 0;
   bit tm    = 1'b0;

   always #10 clk = ~clk;

   dram_cycle_decoder u_dram_cycle_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_n     (ras),
      .cas_n     (cas),
      .we_n      (we),
      .oe_n      (oe),
      .col_sel   (col_sel),
      .arr_pair  (arr_pair),
      .cyc_type  (cyc_type),
      .cyc_valid (cyc_valid),
      .test_mode (test_mode),
      .wr_accept (wr_accept),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe),
      .dq_x      (dq_x)
   );

   always @(posedge clk) begin
      ncyc++;
      if (ncyc > 150000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected<=150000", ncyc);
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic go(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [DQ_W-1:0] exp_dq(input logic [2*DQ_W-1:0] p,
                                              input bit c9, input bit t);
      logic [DQ_W-1:0] r;
      for (int i = 0; i < DQ_W; i++)
         r[i] = t ? ~(p[2*i] ^ p[2*i+1]) : (c9 ? p[2*i+1] : p[2*i]);
      return r;
   endfunction

   task automatic finish_cycle(input int exp, input string rq);
      int hits = 0;
      int typ  = 0;
      ras = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (cyc_valid) begin
            hits++;
            typ = int'(cyc_type);
         end
      end
      chk("R1 valid pulse width", hits, 1);
      chk(rq, typ, exp);
      if (exp == 6) tm = 1'b1;
      if (exp == 4 || exp == 5) tm = 1'b0;
      chk((exp == 4 || exp == 5) ? "R6 test flag" : "R5 test flag", test_mode, tm);
      cas = 1'b1; we = 1'b1; oe = 1'b1;
      go(3);
   endtask

   task automatic do_read(input bit c9, input bit oe_low, input logic [2*DQ_W-1:0] pr);
      arr_pair = pr; col_sel = c9;
      ras = 1'b0; go(3);
      oe = oe_low ? 1'b0 : 1'b1;
      cas = 1'b0; go(12);
      if (oe_low) begin
         chk(tm ? "R8 dq_oe" : "R7 dq_oe", dq_oe, 1);
         chk(tm ? "R8 data" : "R7 data", dq_out, exp_dq(pr, c9, tm));
      end else begin
         chk("R12 dq_oe with OE high", dq_oe, 0);
      end
      finish_cycle(1, "R2 read code");
   endtask

   task automatic do_ewrite();
      int oeh = 0;
      int wr  = 0;
      ras = 1'b0; go(3);
      we = 1'b0; oe = 1'b0; go(3);
      cas = 1'b0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (dq_oe) oeh++;
         if (wr_accept) wr++;
      end
      chk("R9 dq_oe stays low", oeh, 0);
      chk("R9 write accepted once", wr, 1);
      finish_cycle(2, "R9 early write code");
   endtask

   task automatic do_rmw(input bit c9, input logic [2*DQ_W-1:0] pr);
      int wr = 0;
      arr_pair = pr; col_sel = c9;
      ras = 1'b0; go(3);
      oe = 1'b0; cas = 1'b0; go(12);
      chk("R10 read phase dq_oe", dq_oe, 1);
      chk("R10 read phase data", dq_out, exp_dq(pr, c9, tm));
      we = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (wr_accept) wr++;
      end
      chk("R10 write accepted once", wr, 1);
      chk("R10 dq_oe after WE", dq_oe, 0);
      finish_cycle(3, "R10 rmw code");
   endtask

   task automatic do_indet();
      ras = 1'b0; go(3);
      oe = 1'b0; cas = 1'b0; go(1);
      we = 1'b0; go(8);
      chk("R11 dq_x", dq_x, 1);
      chk("R11 dq_oe", dq_oe, 0);
      finish_cycle(7, "R11 indeterminate code");
   endtask

   task automatic do_rasonly();
      oe = 1'b0;
      ras = 1'b0; go(3);
      chk("R3 dq_oe open", dq_oe, 0);
      go(3);
      chk("R3 dq_oe open late", dq_oe, 0);
      finish_cycle(4, "R3 row-only code");
   endtask

   task automatic do_cbr();
      cas = 1'b0; go(3);
      ras = 1'b0; go(4);
      finish_cycle(5, "R4 cbr code");
   endtask

   task automatic do_tentry();
      cas = 1'b0; we = 1'b0; go(3);
      ras = 1'b0; go(4);
      finish_cycle(6, "R5 test entry code");
   endtask

   initial begin
      logic [2*DQ_W-1:0] pr;
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      go(3);
      chk("R13 cyc_valid", cyc_valid, 0);
      chk("R13 test_mode", test_mode, 0);
      chk("R13 dq_oe", dq_oe, 0);
      rst_n = 1'b1;
      go(3);
      chk("R13 cyc_type", cyc_type, 0);
      chk("R13 wr_accept", wr_accept, 0);
      chk("R13 dq_x", dq_x, 0);
      chk("R13 test_mode after release", test_mode, 0);

      do_read(1'b0, 1'b1, 16'hA5C3);
      do_read(1'b1, 1'b1, 16'hA5C3);
      do_read(1'b1, 1'b0, 16'h0F0F);
      do_ewrite();
      do_rmw(1'b1, 16'h3C96);
      do_indet();
      do_rasonly();
      do_cbr();
      do_tentry();
      do_read(1'b0, 1'b1, 16'h9C36);
      do_read(1'b1, 1'b1, 16'h9C36);
      do_ewrite();
      do_rmw(1'b0, 16'hFF00);
      chk("R5 still in test mode", test_mode, 1);
      do_rasonly();
      do_tentry();
      do_cbr();
      do_read(1'b1, 1'b1, 16'h1234);

      for (int it = 0; it < 70; it++) begin
         pr = 16'($urandom);
         case ($urandom_range(7, 0))
            0: do_read(1'($urandom_range(1, 0)), 1'b1, pr);
            1: do_read(1'($urandom_range(1, 0)), 1'b0, pr);
            2: do_ewrite();
            3: do_rmw(1'($urandom_range(1, 0)), pr);
            4: do_indet();
            5: do_rasonly();
            6: do_cbr();
            default: do_tentry();
         endcase
      end

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule